// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is an I2C target that answers one fixed 7-bit device address and lets a bus master read and write a 16-byte register bank through an 8-bit register pointer. The master drives SCL and generates every START and STOP condition. The target watches SCL and SDA and pulls SDA low through an open-drain enable when it acknowledges a byte or sends a zero data bit.

A write transaction sends the device address with direction bit 0. The first byte after it loads the pointer. Each byte after that is stored at the pointer, and the pointer then steps by one. A read transaction sends the device address with direction bit 1. The target then returns bytes starting at the current pointer and steps the pointer after each byte. The pointer keeps its value across transactions. A master can therefore set the pointer in one transaction and read in a later one, or it can use a repeated START to turn a pointer write into a read without releasing the bus.

SCL and SDA are first passed through a two-flop synchronizer. All edge and condition detection runs in the system clock domain, so SCL must be held in each level for several system clocks.

Top module: `i2c_regptr_target`

## Requirements
- R1: After reset the SDA enable is low, the pointer is 0 and every register reads as 0x00.
- R2: An address byte whose upper seven bits are 0x68 (binary 1101000) is acknowledged: SDA is held low during the ninth SCL pulse. Bit 0 of that byte selects write (0) or read (1).
- R3: An address byte with any other upper seven bits gets no acknowledge. SDA stays released until the next START, and bytes sent in that transaction change neither the pointer nor the bank.
- R4: In a write transaction, the first byte after the address byte is acknowledged and loads the pointer.
- R5: Every later write byte is acknowledged, stored in register (pointer mod 16), and then the pointer increments by one.
- R6: A read transaction returns bytes MSB first, starting with register (pointer mod 16), and increments the pointer after each byte.
- R7: A read that has no pointer write before it starts from the value the pointer held at the end of the previous transaction.
- R8: When the master answers a read byte with a not-acknowledge (SDA high in the ninth pulse), the target stops sending and keeps SDA released until the next START. The pointer has then advanced by exactly the number of bytes sent.
- R9: A repeated START ends the current transfer and begins a new address phase. A write that sets the pointer followed by a repeated START and a read returns data from that pointer.
- R10: A STOP ends any transfer and leaves SDA released.
- R11: The pointer is 8 bits wide and wraps from 0xFF to 0x00. The bank is indexed by its low four bits, so 0xFE, 0xFF and 0x00 address registers 14, 15 and 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCL and SDA are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the bus (the wired-AND of all drivers) |
| sda_oe | output | 1 | When high, the pad pulls SDA low; when low, SDA is released |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it makes a START or STOP. They also assume that each SCL level lasts well beyond the synchronizer delay, so the target's SDA changes settle inside the low phase. The bench master holds each quarter of a bit period for eight system clocks, and it forms START, repeated START and STOP only with SCL high and the target not driving. The SDA the bench observes is the wired-AND of the master's drive and the target's enable, as on a real open-drain bus.

// File: rtl/i2c_tgt_pkg.sv
// Package: i2c_tgt_pkg
// Shared constants and the transfer-state type for the I2C register-pointer
// target. Assumes byte-wide registers and an 8-bit pointer.
package i2c_tgt_pkg;

    localparam int          BYTE_W       = 8;
    localparam int          PTR_W        = 8;
    localparam logic [6:0]  DEFAULT_ADDR = 7'h68;

    typedef enum logic [2:0] {
        XS_IDLE,   // released, waiting for a START
        XS_ADDR,   // shifting in the address byte
        XS_RECV,   // shifting in a pointer or data byte
        XS_ACK,    // target holds SDA low for the acknowledge
        XS_SEND,   // target shifts a read byte onto SDA
        XS_MACK    // SDA released, sampling the master's acknowledge
    } xfer_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the system clock domain through a flop chain and
// derives SCL edges plus START / STOP conditions from the synchronized levels.
// Assumes the bus lines are slow against clk (several clocks per SCL level).
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;

    // Shift both lines through the synchronizer and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_in};
            sda_chain <= {sda_chain[STAGES-2:0], sda_in};
            scl_prev  <= scl_chain[TOP];
            sda_prev  <= sda_chain[TOP];
        end
    end

    // Decode edges and bus conditions from the current and previous samples.
    always_comb begin
        sda_lvl   = sda_chain[TOP];
        scl_rise  =  scl_chain[TOP] & ~scl_prev;
        scl_fall  = ~scl_chain[TOP] &  scl_prev;
        start_det =  scl_chain[TOP] & scl_prev &  sda_prev & ~sda_chain[TOP];
        stop_det  =  scl_chain[TOP] & scl_prev & ~sda_prev &  sda_chain[TOP];
    end

endmodule

// File: rtl/i2c_reg_bank.sv
// Module: i2c_reg_bank
// Small register array with one synchronous write port and one
// combinational read port. Contents carry no meaning; all entries reset to 0.
module i2c_reg_bank #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] cells [DEPTH];

    // Clear every cell on reset, otherwise store on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
    end

    // Present the addressed cell on the read port.
    always_comb begin
        rd_data = cells[rd_idx];
    end

endmodule

// File: rtl/i2c_xfer_engine.sv
// Module: i2c_xfer_engine
// Byte-level transfer controller: decodes the address byte, loads and steps
// the register pointer, drives acknowledges and read data on SDA, and samples
// the master's acknowledge. Assumes SCL edges and START/STOP arrive as
// single-cycle strobes from i2c_line_sync, and that SDA only changes under the
// engine's control while SCL is low.
module i2c_xfer_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = DEFAULT_ADDR,
    parameter int         IDX_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  ptr_q,
    output logic              ptr_loaded,
    output logic              idle,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [BYTE_W-1:0] rd_data
);

    localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);

    xfer_state_e       state;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              dir_read;
    logic              want_ptr;
    logic              master_ack;

    // Read port always follows the pointer's low bits.
    always_comb begin
        rd_idx = ptr_q[IDX_W-1:0];
        idle   = (state == XS_IDLE);
    end

    // Main transfer sequencer, advanced by SCL edges and bus conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= XS_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            sda_oe     <= 1'b0;
            dir_read   <= 1'b0;
            want_ptr   <= 1'b0;
            master_ack <= 1'b0;
            ptr_q      <= '0;
            ptr_loaded <= 1'b0;
            wr_en      <= 1'b0;
            wr_idx     <= '0;
            wr_data    <= '0;
        end else begin
            wr_en      <= 1'b0;
            ptr_loaded <= 1'b0;
            if (start_det) begin
                state   <= XS_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state   <= XS_IDLE;
                sda_oe  <= 1'b0;
            end else begin
                unique case (state)
                    XS_IDLE: begin
                    end
                    XS_ADDR, XS_RECV: begin
                        if (scl_rise && bit_cnt < BITS_PER_BYTE) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == BITS_PER_BYTE) begin
                            bit_cnt <= '0;
                            if (state == XS_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    dir_read <= shreg[0];
                                    want_ptr <= ~shreg[0];
                                    sda_oe   <= 1'b1;
                                    state    <= XS_ACK;
                                end else begin
                                    state    <= XS_IDLE;
                                end
                            end else begin
                                if (want_ptr) begin
                                    ptr_q      <= shreg;
                                    want_ptr   <= 1'b0;
                                    ptr_loaded <= 1'b1;
                                end else begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= ptr_q[IDX_W-1:0];
                                    wr_data <= shreg;
                                    ptr_q   <= ptr_q + 1'b1;
                                end
                                sda_oe <= 1'b1;
                                state  <= XS_ACK;
                            end
                        end
                    end
                    XS_ACK: begin
                        if (scl_fall) begin
                            if (dir_read) begin
                                shreg   <= rd_data;
                                sda_oe  <= ~rd_data[BYTE_W-1];
                                ptr_q   <= ptr_q + 1'b1;
                                bit_cnt <= 4'd1;
                                state   <= XS_SEND;
                            end else begin
                                sda_oe  <= 1'b0;
                                state   <= XS_RECV;
                            end
                        end
                    end
                    XS_SEND: begin
                        if (scl_fall) begin
                            if (bit_cnt == BITS_PER_BYTE) begin
                                sda_oe <= 1'b0;
                                state  <= XS_MACK;
                            end else begin
                                sda_oe  <= ~shreg[BYTE_W-2];
                                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    XS_MACK: begin
                        if (scl_rise) begin
                            master_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (master_ack) begin
                                shreg   <= rd_data;
                                sda_oe  <= ~rd_data[BYTE_W-1];
                                ptr_q   <= ptr_q + 1'b1;
                                bit_cnt <= 4'd1;
                                state   <= XS_SEND;
                            end else begin
                                state   <= XS_IDLE;
                            end
                        end
                    end
                    default: state <= XS_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_regptr_target.sv
// Module: i2c_regptr_target
// Top level of the I2C register-pointer target: line synchronizer, transfer
// engine and register bank. sda_oe high means the pad pulls SDA low.
// Assumes an external pull-up and a master that owns SCL (no stretching).
module i2c_regptr_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = DEFAULT_ADDR,
    parameter int         REG_DEPTH   = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);

    localparam int IDX_W = $clog2(REG_DEPTH);

    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [PTR_W-1:0]  ptr_q;
    logic              ptr_loaded;
    logic              eng_idle;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [IDX_W-1:0]  rd_idx;
    logic [BYTE_W-1:0] rd_data;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_xfer_engine #(
        .DEV_ADDR (DEV_ADDR),
        .IDX_W    (IDX_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_lvl    (sda_lvl),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .sda_oe     (sda_oe),
        .ptr_q      (ptr_q),
        .ptr_loaded (ptr_loaded),
        .idle       (eng_idle),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data)
    );

    i2c_reg_bank #(
        .DEPTH (REG_DEPTH),
        .WIDTH (BYTE_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/i2c_regptr_target_chk.sv
// Module: i2c_regptr_target_chk
// Property checker bound to i2c_regptr_target. Assumes SCL stays low for
// several clocks after each falling edge, as a real bus master guarantees.
module i2c_regptr_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_in,
    input logic       sda_oe,
    input logic       start_det,
    input logic       stop_det,
    input logic       idle,
    input logic [7:0] ptr_q,
    input logic       ptr_loaded
);

    logic was_in_reset;

    // Check the state presented in the first cycle after reset (R1).
    always_ff @(posedge clk) begin
        was_in_reset <= !rst_n;
        if (was_in_reset && rst_n) begin
            a_r1_reset_state: assert (!sda_oe && ptr_q == 8'h00)
                else $error("R1: not released or pointer nonzero after reset");
        end
    end

    // R2: the target only starts pulling SDA low while SCL is low.
    a_r2_drive_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_in);

    // R3 / R8: whenever the engine is idle, SDA is released.
    a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !sda_oe);

    // R9: a START always leaves SDA released.
    a_r9_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R10: a STOP always leaves SDA released.
    a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R11: outside a pointer load, the pointer only steps by one (mod 256).
    a_r11_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q != $past(ptr_q)) && !ptr_loaded |-> ptr_q == $past(ptr_q) + 8'd1);

endmodule

bind i2c_regptr_target i2c_regptr_target_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_in),
    .sda_oe     (sda_oe),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .idle       (eng_idle),
    .ptr_q      (ptr_q),
    .ptr_loaded (ptr_loaded)
);

// File: tb/tb_i2c_regptr_target.sv
// Bench: drives the target as a bus master over an open-drain model and keeps
// its own arithmetic model of the bank and pointer.
module tb_i2c_regptr_target;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 8;
    localparam int WATCHDOG   = 190000;
    localparam logic [6:0] DEV = 7'h68;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic done = 1'b0;

    int errors = 0;
    int checks = 0;

    logic [7:0] model [16];
    logic [7:0] mptr;

    assign sda_bus = m_sda & ~sda_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_regptr_target dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (m_scl),
        .sda_in (sda_bus),
        .sda_oe (sda_oe)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b0; tick();
        m_scl = 1'b0; tick();
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; tick();
        m_scl = 1'b1; tick();
        m_sda = 1'b0; tick();
        m_scl = 1'b0; tick();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick();
        m_scl = 1'b1; tick();
        m_sda = 1'b1; tick();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick();
            m_scl = 1'b1; tick(); tick();
            m_scl = 1'b0; tick();
        end
        m_sda = 1'b1; tick();
        m_scl = 1'b1; tick();
        acked = !sda_bus; tick();
        m_scl = 1'b0; tick();
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick();
            m_scl = 1'b1; tick();
            b[i] = sda_bus; tick();
            m_scl = 1'b0;
        end
        m_sda = nack; tick();
        m_scl = 1'b1; tick(); tick();
        m_scl = 1'b0; tick();
        m_sda = 1'b1;
    endtask

    // Write transaction: pointer byte then n data bytes from an arithmetic pattern.
    task automatic do_write(input logic [7:0] p, input int n, input int seed);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        check(ack, "R2 write address ack", ack, 1);
        send_byte(p, ack);
        check(ack, "R4 pointer byte ack", ack, 1);
        mptr = p;
        for (int k = 0; k < n; k++) begin
            d = 8'((seed + k * 37) & 255);
            send_byte(d, ack);
            check(ack, "R5 data byte ack", ack, 1);
            model[mptr[3:0]] = d;
            mptr = mptr + 8'd1;
        end
        bus_stop();
        check(!sda_oe, "R10 released after stop", sda_oe, 0);
    endtask

    // Read transaction of n bytes; optionally set pointer first via repeated START.
    task automatic do_read(input int n, input logic set_ptr, input logic [7:0] p, input string req);
        logic ack;
        logic [7:0] got;
        bus_start();
        if (set_ptr) begin
            send_byte({DEV, 1'b0}, ack);
            check(ack, "R9 address ack before repeated start", ack, 1);
            send_byte(p, ack);
            check(ack, "R4 pointer ack before repeated start", ack, 1);
            mptr = p;
            bus_rstart();
        end
        send_byte({DEV, 1'b1}, ack);
        check(ack, "R2 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, got);
            check(got == model[mptr[3:0]], req, got, model[mptr[3:0]]);
            mptr = mptr + 8'd1;
        end
        bus_stop();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] got;
        logic [7:0] wrong;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        mptr = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: released, bank zero, pointer zero (first read hits register 0).
        check(!sda_oe, "R1 released after reset", sda_oe, 0);
        do_read(2, 1'b0, 8'h00, "R1 reset contents and pointer");

        // R5 / R9: fill the bank, read it back through a repeated START.
        do_write(8'h00, 16, 5);
        do_read(16, 1'b1, 8'h00, "R9 read after repeated start");

        // R7: pointer set in one transaction, read in later ones, for every register.
        for (int p = 0; p < 16; p++) begin
            do_write(8'(p), 0, 0);
            do_read(3, 1'b0, 8'h00, "R7 read from stored pointer");
            do_read(1, 1'b0, 8'h00, "R6 pointer advanced across reads");
        end

        // R11: pointer wrap 0xFE -> 0xFF -> 0x00 and index modulo 16.
        do_write(8'hFE, 3, 200);
        do_read(2, 1'b0, 8'h00, "R11 read after pointer wrap");
        do_read(3, 1'b1, 8'd14, "R11 registers 14, 15, 0");

        // R9: two write phases joined by a repeated START.
        bus_start();
        send_byte({DEV, 1'b0}, ack); check(ack, "R9 first phase ack", ack, 1);
        send_byte(8'h23, ack);        check(ack, "R4 pointer 0x23 ack", ack, 1);
        send_byte(8'hA5, ack);        check(ack, "R5 data ack", ack, 1);
        model[3] = 8'hA5;
        bus_rstart();
        send_byte({DEV, 1'b0}, ack); check(ack, "R9 second phase ack", ack, 1);
        send_byte(8'h09, ack);        check(ack, "R4 pointer 0x09 ack", ack, 1);
        send_byte(8'h5A, ack);        check(ack, "R5 data ack", ack, 1);
        model[9] = 8'h5A;
        mptr = 8'h0A;
        bus_stop();
        do_read(1, 1'b1, 8'h03, "R9 value from first phase");
        do_read(1, 1'b1, 8'h09, "R9 value from second phase");

        // R8: after a NACK the target stays released; pointer stepped once.
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        check(ack, "R2 read address ack", ack, 1);
        recv_byte(1'b1, got);
        check(got == model[mptr[3:0]], "R8 byte before nack", got, model[mptr[3:0]]);
        mptr = mptr + 8'd1;
        recv_byte(1'b1, got);
        check(got == 8'hFF, "R8 bus released after nack", got, 8'hFF);
        bus_stop();
        do_read(1, 1'b0, 8'h00, "R8 pointer advanced once");

        // R3: every other address gets no acknowledge, nor does the byte after it.
        for (int a = 0; a < 128; a++) begin
            if (7'(a) != DEV) begin
                wrong = {7'(a), a[0]};
                bus_start();
                send_byte(wrong, ack);
                check(!ack, "R3 no ack on foreign address", ack, 0);
                send_byte(8'h00, ack);
                check(!ack, "R3 no ack after foreign address", ack, 0);
                bus_stop();
            end
        end
        do_read(4, 1'b0, 8'h00, "R3 bank and pointer untouched");
        check(!sda_oe, "R10 released at end", sda_oe, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule